// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a bank of 32-bit chip-control words reached through a simple synchronous register bus. Each bus request is one cycle wide and carries a write flag, a byte address and write data. A read returns its word one cycle later, flagged by a response-valid strobe. The bus takes one request in every cycle and never stalls. There is no back-pressure: the requester may issue a new access in every cycle, and the responder must accept each read result in the cycle it is presented.

Most of the lower half of the map is guarded by a key word held at offset 0x00. Writes into the guarded window land only while that word equals the unlock constant. A handful of offsets are read-only, and one offset is write-only. Addresses that are misaligned or beyond the map are refused. Each kind of refusal raises its own one-cycle error pulse.

At reset the bank loads the defaults chosen by a revision parameter. The revision value and two board strap inputs are then placed in their dedicated words.

Top module: `scr_top`

## Requirements
- R1: While reset is held, every word loads its revision default. For revision 0x02000303 these are 0x04=0xFFCFFEDC, 0x08=0xF3F40000, 0x40=0x000000C0, 0x9C=0x003FFFF3 and 0x1A4=0x00002402. Every other word that R2 does not name resets to zero.
- R2: After reset, offset 0x7C holds the revision parameter, offset 0x70 holds `strap_a_i` and offset 0xD0 holds `strap_b_i`, all sampled while reset is low.
- R3: A write to an offset in 0x04..0x100 inclusive is dropped while the word at 0x00 differs from 0x1688A8A8. Such a write pulses `err_locked_o`, and this takes priority over the read-only error.
- R4: Writes to offset 0x00 and to offsets 0x104..0x1A4 are always stored. Any value other than 0x1688A8A8 written to 0x00 re-locks the window.
- R5: Writes to offsets 0x14, 0x50..0x6C, 0x78, 0x7C, 0xE0 and 0xE4 never change them. When not already refused by R3, such a write pulses `err_readonly_o`.
- R6: An access at offset 0x1A8 or above changes nothing and pulses `err_range_o`. A read there returns zero.
- R7: An access whose address has nonzero bits [1:0] behaves as in R6.
- R8: A read of offset 0xC0 returns its stored value and pulses `err_wronly_o`. Writes to 0xC0 are stored normally.
- R9: `rsp_valid_o` is high exactly in the cycle after a read request, with the data on `rsp_rdata_o`. Otherwise `rsp_rdata_o` is zero. Back-to-back requests are served with no gaps.
- R10: Error pulses last one cycle, appear in the cycle after the offending request, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a_i | input | 32 | First board strap word, loaded at reset |
| strap_b_i | input | 32 | Second board strap word, loaded at reset |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| err_locked_o | output | 1 | Write refused by the key lock |
| err_readonly_o | output | 1 | Write to a read-only word |
| err_range_o | output | 1 | Out-of-map or misaligned access |
| err_wronly_o | output | 1 | Read of the write-only word |

## Verification
The bench writes a distinct pattern to every word of the map, once while locked and once while unlocked, and reads the whole map back after each pass. A design with the guard window off by one word would therefore corrupt 0x100 or refuse 0x104, and a wrong read-only list would let one of those words change. It also writes a near-miss key, re-locks with zero, and reads the write-only word. It probes the first out-of-map address and misaligned addresses, where a sloppy decode would alias onto a real word. A second reset with new strap values catches straps that are latched once rather than on every reset.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t UNLOCK_WORD = 32'h1688_A8A8;
  localparam word_t REV_A       = 32'h0200_0303;

  localparam int unsigned IDX_KEY     = 0;
  localparam int unsigned IDX_STRAP_A = 28;  // 0x70
  localparam int unsigned IDX_REV     = 31;  // 0x7C
  localparam int unsigned IDX_WONLY   = 48;  // 0xC0
  localparam int unsigned IDX_STRAP_B = 52;  // 0xD0
  localparam int unsigned PROT_LAST   = 64;  // 0x100, last guarded word

  typedef struct packed {
    logic locked;
    logic readonly;
    logic range;
    logic wronly;
  } scr_err_t;

  function automatic logic is_readonly(int unsigned idx);
    return (idx == 5) || (idx >= 20 && idx <= 27) || (idx == 30) ||
           (idx == 31) || (idx == 56) || (idx == 57);
  endfunction

  function automatic word_t rev_default(word_t rev, int unsigned idx);
    word_t v;
    v = '0;
    if (rev == REV_A) begin
      case (idx)
        1:       v = 32'hFFCF_FEDC;
        2:       v = 32'hF3F4_0000;
        16:      v = 32'h0000_00C0;
        39:      v = 32'h003F_FFF3;
        105:     v = 32'h0000_2402;
        default: v = '0;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/scr_decode.sv
module scr_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 106,
  parameter int unsigned IDX_W    = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o,
  output logic              prot_o,
  output logic              ro_o,
  output logic              wo_o
);
  import scr_pkg::*;

  localparam int unsigned SEL_W = ADDR_W - 2;
  localparam logic [SEL_W-1:0] LIMIT    = SEL_W'(NUM_REGS);
  localparam logic [SEL_W-1:0] PROT_TOP = SEL_W'(PROT_LAST);
  localparam logic [SEL_W-1:0] WO_SEL   = SEL_W'(IDX_WONLY);

  logic [SEL_W-1:0] word_sel;
  logic             aligned;

  assign word_sel = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign hit_o    = aligned && (word_sel < LIMIT);
  assign idx_o    = word_sel[IDX_W-1:0];
  assign prot_o   = hit_o && (word_sel != '0) && (word_sel <= PROT_TOP);
  assign ro_o     = hit_o && is_readonly(int'(word_sel));
  assign wo_o     = hit_o && (word_sel == WO_SEL);
endmodule

// File: rtl/scr_bank.sv
module scr_bank #(
  parameter int unsigned  NUM_REGS = 106,
  parameter int unsigned  IDX_W    = 7,
  parameter scr_pkg::word_t REV_ID = scr_pkg::REV_A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scr_pkg::word_t       strap_a_i,
  input  scr_pkg::word_t       strap_b_i,
  input  logic                 wr_req_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic                 wr_hit_i,
  input  logic                 wr_prot_i,
  input  logic                 wr_ro_i,
  input  scr_pkg::word_t       wr_data_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output scr_pkg::word_t       rd_word_o,
  output logic                 locked_o
);
  import scr_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  word_t regs_q [NUM_REGS];
  logic  commit;

  assign locked_o = (regs_q[IDX_KEY] != UNLOCK_WORD);
  assign commit   = wr_req_i && wr_hit_i && !wr_ro_i && !(wr_prot_i && locked_o);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
    word_t init_val;
    if (gi == IDX_STRAP_A) begin : g_sa
      assign init_val = strap_a_i;
    end else if (gi == IDX_STRAP_B) begin : g_sb
      assign init_val = strap_b_i;
    end else if (gi == IDX_REV) begin : g_rev
      assign init_val = REV_ID;
    end else begin : g_tab
      assign init_val = rev_default(REV_ID, gi);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[gi] <= init_val;
      else if (commit && (wr_idx_i == IDX_W'(gi)))
        regs_q[gi] <= wr_data_i;
    end

    // R3: a guarded word never changes while the window is locked
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_i && wr_hit_i && wr_prot_i && locked_o && wr_idx_i == IDX_W'(gi))
      |=> $stable(regs_q[gi]));

    // R5: read-only words keep their value across writes
    p_ro_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_i && wr_hit_i && wr_ro_i && wr_idx_i == IDX_W'(gi))
      |=> $stable(regs_q[gi]));
  end

  assign rd_word_o = (rd_idx_i <= LAST_IDX) ? regs_q[rd_idx_i] : '0;

  // R2: the revision word always carries the revision parameter
  p_rev_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[IDX_REV] == REV_ID);
endmodule

// File: rtl/scr_top.sv
module scr_top #(
  parameter int unsigned    ADDR_W   = 12,
  parameter int unsigned    NUM_REGS = 106,
  parameter scr_pkg::word_t REV_ID   = scr_pkg::REV_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       strap_a_i,
  input  logic [31:0]       strap_b_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              err_locked_o,
  output logic              err_readonly_o,
  output logic              err_range_o,
  output logic              err_wronly_o
);
  import scr_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic             hit, prot, ro, wo, locked;
  word_t            rd_word;
  scr_err_t         err_d, err_q;
  logic             rd_req;

  scr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .addr_i (req_addr_i),
    .idx_o  (idx),
    .hit_o  (hit),
    .prot_o (prot),
    .ro_o   (ro),
    .wo_o   (wo)
  );

  scr_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .REV_ID(REV_ID)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_a_i (strap_a_i),
    .strap_b_i (strap_b_i),
    .wr_req_i  (req_valid_i && req_write_i),
    .wr_idx_i  (idx),
    .wr_hit_i  (hit),
    .wr_prot_i (prot),
    .wr_ro_i   (ro),
    .wr_data_i (req_wdata_i),
    .rd_idx_i  (idx),
    .rd_word_o (rd_word),
    .locked_o  (locked)
  );

  assign rd_req          = req_valid_i && !req_write_i;
  assign err_d.range     = req_valid_i && !hit;
  assign err_d.locked    = req_valid_i && req_write_i && prot && locked;
  assign err_d.readonly  = req_valid_i && req_write_i && ro && !(prot && locked);
  assign err_d.wronly    = rd_req && wo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      err_q       <= '0;
    end else begin
      rsp_valid_o <= rd_req;
      rsp_rdata_o <= (rd_req && hit) ? rd_word : '0;
      err_q       <= err_d;
    end
  end

  assign err_locked_o   = err_q.locked;
  assign err_readonly_o = err_q.readonly;
  assign err_range_o    = err_q.range;
  assign err_wronly_o   = err_q.wronly;

  // R9: response strobe follows each read request by one cycle
  p_rsp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid_o);
  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> (rsp_rdata_o == '0));
  // R10: never more than one error class at once
  p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_locked_o, err_readonly_o, err_range_o, err_wronly_o}));
  // R10: no error without a request in the previous cycle
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !(err_locked_o || err_readonly_o || err_range_o || err_wronly_o));
  // R6: refused reads return zero
  p_range_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !hit) |=> (rsp_rdata_o == '0));
endmodule

// File: tb/tb_scr_top.sv
module tb_scr_top;
  localparam int unsigned N   = 106;
  localparam logic [31:0] KEY = 32'h1688_A8A8;
  localparam logic [31:0] REV = 32'h0200_0303;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] strap_a = 32'hA11C_E001, strap_b = 32'hB0B0_1234;
  logic        vld = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rvld;
  logic [31:0] rdata;
  logic        e_lk, e_ro, e_rg, e_wo;

  int tests = 0, fails = 0;
  logic [31:0] model [N];

  always #5 clk = ~clk;

  scr_top dut (
    .clk(clk), .rst_n(rst_n), .strap_a_i(strap_a), .strap_b_i(strap_b),
    .req_valid_i(vld), .req_write_i(wr), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rvld), .rsp_rdata_o(rdata),
    .err_locked_o(e_lk), .err_readonly_o(e_ro), .err_range_o(e_rg), .err_wronly_o(e_wo)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic ro_word(int unsigned i);
    return (i == 5) || (i >= 20 && i <= 27) || (i == 30) || (i == 31) || (i == 56) || (i == 57);
  endfunction

  function automatic logic [31:0] dflt(int unsigned i);
    case (i)
      1: return 32'hFFCF_FEDC;
      2: return 32'hF3F4_0000;
      16: return 32'h0000_00C0;
      39: return 32'h003F_FFF3;
      105: return 32'h0000_2402;
      28: return strap_a;
      31: return REV;
      52: return strap_b;
      default: return 32'h0;
    endcase
  endfunction

  // expected outcome of one access; updates model
  task automatic predict(input logic w, input logic [11:0] a, input logic [31:0] d,
                         output logic [3:0] err, output logic [31:0] rd);
    int unsigned i;
    logic hit, prot, lk;
    i    = int'(a >> 2);
    hit  = (a[1:0] == 2'b00) && (i < N);
    prot = hit && i >= 1 && i <= 64;
    lk   = w && prot && (model[0] != KEY);
    err  = {lk, w && hit && ro_word(i) && !lk, !hit, !w && hit && i == 48};
    rd   = (!w && hit) ? model[i] : 32'h0;
    if (w && hit && !lk && !ro_word(i)) model[i] = d;
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [3:0] xe;
    logic [31:0] xr;
    predict(w, a, d, xe, xr);
    @(negedge clk);
    vld = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    vld = 0; wr = 0;
    check({e_lk, e_ro, e_rg, e_wo} == xe, {tag, " R10 err flags"}, {28'h0, e_lk, e_ro, e_rg, e_wo}, {28'h0, xe});
    check(rvld == !w, {tag, " R9 rsp_valid"}, {31'h0, rvld}, {31'h0, !w});
    if (!w) check(rdata == xr, {tag, " rdata"}, rdata, xr);
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) model[i] = dflt(i);
    check(rvld == 0 && {e_lk, e_ro, e_rg, e_wo} == 0, "R9 outputs idle in reset", {31'h0, rvld}, 0);
    rst_n = 1;
  endtask

  task automatic sweep_read(input string tag);
    for (int i = 0; i < N; i++) access(0, 12'(i * 4), 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] xe;
    logic [31:0] xr [3];
    do_reset();
    // R1 R2 R8: default table, straps, write-only read
    sweep_read("R1/R2 reset defaults");
    // R3: locked writes to all words except key
    for (int i = 1; i < N; i++) access(1, 12'(i * 4), {8'(i), 8'hC3, 8'(~i), 8'h5A}, "R3/R4 locked write");
    sweep_read("R3/R4 after locked writes");
    // near-miss key keeps lock
    access(1, 12'h000, KEY ^ 32'h1, "R4 near key");
    access(1, 12'h004, 32'hDEAD_0001, "R3 still locked");
    access(0, 12'h004, 0, "R3 still locked readback");
    access(1, 12'h000, KEY, "R4 unlock");
    for (int i = 1; i < N; i++) access(1, 12'(i * 4), {8'h3C, 8'(i), 8'h96, 8'(~i)}, "R5 unlocked write");
    sweep_read("R5 after unlocked writes");
    // R6 R7: out of range and misaligned
    access(0, 12'h1A8, 0, "R6 first beyond");
    access(1, 12'h1A8, 32'hFFFF_FFFF, "R6 write beyond");
    access(0, 12'hFFC, 0, "R6 top");
    access(1, 12'h005, 32'h1234_5678, "R7 misaligned write");
    access(0, 12'h042, 0, "R7 misaligned read");
    access(1, 12'h1A7, 32'h0BAD_0BAD, "R7 misaligned near end");
    access(0, 12'h004, 0, "R7 word 0x04 untouched");
    access(0, 12'h1A4, 0, "R6 last word untouched");
    // R8: write to 0xC0 stored, read flagged
    access(1, 12'h0C0, 32'hC0C0_5555, "R8 write");
    access(0, 12'h0C0, 0, "R8 read");
    // R4: relock via zero key
    access(1, 12'h000, 32'h0, "R4 relock");
    access(1, 12'h100, 32'h0000_0100, "R3 edge 0x100 locked");
    access(1, 12'h104, 32'h0000_0104, "R4 edge 0x104 free");
    access(0, 12'h100, 0, "R3 edge readback");
    access(0, 12'h104, 0, "R4 edge readback");
    // R9: back-to-back reads
    predict(0, 12'h104, 0, xe, xr[0]);
    predict(0, 12'h0C0, 0, xe, xr[1]);
    predict(0, 12'h1A4, 0, xe, xr[2]);
    @(negedge clk); vld = 1; wr = 0; addr = 12'h104;
    @(negedge clk); addr = 12'h0C0;
    check(rvld && rdata == xr[0], "R9 burst 0", rdata, xr[0]);
    @(negedge clk); addr = 12'h1A4;
    check(rvld && rdata == xr[1] && e_wo, "R9 burst 1", rdata, xr[1]);
    @(negedge clk); vld = 0;
    check(rvld && rdata == xr[2], "R9 burst 2", rdata, xr[2]);
    @(negedge clk);
    check(!rvld && rdata == 0, "R9 idle zero", rdata, 0);
    // R1 R2: second reset with new straps
    strap_a = 32'h5EED_0A0A; strap_b = 32'h0F0F_F0F0;
    do_reset();
    sweep_read("R1/R2 second reset");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule